// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Self-Refresh Strobe Sequencer

This block drives the three active-low control strobes of an asynchronous EDO DRAM (row strobe `ras_n`, column strobe `cas_n`, write strobe `we_n`) through the timing of a CAS-before-RAS refresh cycle. It also drives the strobes for entry into and exit from low-power self refresh. It runs on the memory controller's clock. Every minimum interval is a nanosecond parameter that is turned into a whole number of clock cycles by ceiling division, so an interval is never shorter than its minimum.

A refresh scheduler issues one operation at a time through a valid/ready handshake. The operations are a single refresh cycle, enter self refresh, and exit self refresh. When an operation cannot start yet, the sequencer holds the request off by keeping `req_ready` low. A request is never lost. While the device rests in self refresh, both strobes stay low and the sequencer is not busy. An exit request is only accepted once the minimum self-refresh time has passed, and an early exit request waits until then. The write strobe stays inactive throughout, so the device sees a refresh and never a test-mode entry. Address generation, normal accesses and refresh scheduling belong to other blocks.

Top module: `cbr_refresh_seq`

## Requirements
- R1: `we_n` is high in every cycle, including during reset and across every sequence.
- R2: Every interval X is converted as ceil(X_NS*1000/CLK_PS) cycles, with a minimum of 1. For a refresh request (`req_kind` = 0), `cas_n` goes low in the first cycle after acceptance, and `ras_n` goes low exactly CSR cycles later while `cas_n` stays low.
- R3: In a refresh cycle, `ras_n` stays low for max(RAS, CHR) cycles with `cas_n` low throughout, and both strobes rise in the same cycle.
- R4: After the refresh cycle's strobes rise, both stay high for RP cycles. The sequencer then returns to idle.
- R5: For an enter request (`req_kind` = 1), `cas_n` falls in the first cycle after acceptance and `ras_n` falls CSR cycles later. Both then stay low until an exit is accepted.
- R6: An exit request (`req_kind` = 2) is accepted only once both strobes have been low for at least RASS cycles. Before that, `req_ready` stays low and the request waits.
- R7: After exit acceptance, `ras_n` rises in the next cycle and `cas_n` stays low for CHD cycles. Both strobes are then high for RP_SR cycles before the return to idle.
- R8: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in idle for kinds 0 and 1, and in self refresh (after R6's wait) for kind 2. Kind 3 is never accepted.
- R9: `busy` is high from the cycle after an acceptance through the last cycle of that operation. It is low in idle and while resting in self refresh.
- R10: `done` is a one-cycle pulse in the first cycle after an operation completes: return to idle, or for entry, the first cycle with both strobes low.
- R11: A synchronous active-high reset returns the sequencer to idle, with all strobes high and `busy` and `done` low. This holds even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request present |
| req_kind | input | 2 | 0 refresh, 1 enter self refresh, 2 exit self refresh, 3 unused |
| req_ready | output | 1 | Request can be accepted this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held inactive high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the embedded assertions check the timing relations between the strobes. They check that the column strobe leads the row strobe by the setup count, and that the column strobe holds long enough after the row strobe falls. They check the self-refresh low time at exit, the column-strobe hold after the row strobe rises at exit, the permanently high write strobe, and that `ready` is never high while the sequencer is busy. Only the bench's scenarios show the exact placement of each edge, the precharge lengths, and which requests are held off and when they are finally accepted. The same is true of the `done` and `busy` framing, back-to-back refreshes from a held request, and recovery from a reset in the middle of a sequence. The bench checks these against a queue-based model of the expected strobe waveform on every cycle.

// File: rtl/cbr_seq_pkg.sv
package cbr_seq_pkg;

    typedef enum logic [1:0] {
        KIND_CBR      = 2'd0,
        KIND_SR_ENTER = 2'd1,
        KIND_SR_EXIT  = 2'd2,
        KIND_NONE     = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CBR_SETUP,
        ST_CBR_ACTIVE,
        ST_CBR_PRECH,
        ST_SR_SETUP,
        ST_SR_HOLD,
        ST_SR_RELEASE,
        ST_SR_PRECH
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Ceiling conversion of a nanosecond minimum to clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels held during each state; the write strobe never activates.
    function automatic strobe_t strobes_for(input seq_state_e s);
        strobe_t v;
        v = STROBES_IDLE;
        unique case (s)
            ST_CBR_SETUP, ST_SR_SETUP, ST_SR_RELEASE: v.cas_n = 1'b0;
            ST_CBR_ACTIVE, ST_SR_HOLD: begin
                v.cas_n = 1'b0;
                v.ras_n = 1'b0;
            end
            default: v = STROBES_IDLE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cbr_step_timer.sv
module cbr_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    a_r2_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/cbr_strobe_reg.sv
module cbr_strobe_reg
    import cbr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_nxt,
    output strobe_t    strobes
);
    // Strobes come straight from flops so the DRAM pins never see decode glitches.
    always_ff @(posedge clk) begin
        if (rst) begin
            strobes <= STROBES_IDLE;
        end else begin
            strobes <= strobes_for(state_nxt);
        end
    end

    a_r1_we_never_active: assert property (@(posedge clk) disable iff (rst)
        strobes.we_n);

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
    import cbr_seq_pkg::*;
#(
    parameter int CLK_PS  = 4000,
    parameter int CSR_NS  = 5,
    parameter int CHR_NS  = 10,
    parameter int RAS_NS  = 60,
    parameter int RP_NS   = 40,
    parameter int RASS_NS = 100000,
    parameter int CHD_NS  = 10,
    parameter int RPS_NS  = 110
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       req_ready,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       busy,
    output logic       done
);
    localparam int CSR_CYC  = ns_to_cycles(CSR_NS, CLK_PS);
    localparam int CHR_CYC  = ns_to_cycles(CHR_NS, CLK_PS);
    localparam int RAS_CYC  = max_int(ns_to_cycles(RAS_NS, CLK_PS), CHR_CYC);
    localparam int RP_CYC   = ns_to_cycles(RP_NS, CLK_PS);
    localparam int RASS_CYC = ns_to_cycles(RASS_NS, CLK_PS);
    localparam int CHD_CYC  = ns_to_cycles(CHD_NS, CLK_PS);
    localparam int RPS_CYC  = ns_to_cycles(RPS_NS, CLK_PS);
    localparam int MAX_CYC  = max_int(max_int(max_int(CSR_CYC, RAS_CYC), max_int(RP_CYC, RASS_CYC)),
                                      max_int(CHD_CYC, RPS_CYC));
    localparam int TW       = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] LD_CSR  = TW'(CSR_CYC - 1);
    localparam logic [TW-1:0] LD_RAS  = TW'(RAS_CYC - 1);
    localparam logic [TW-1:0] LD_RP   = TW'(RP_CYC - 1);
    localparam logic [TW-1:0] LD_RASS = TW'(RASS_CYC - 1);
    localparam logic [TW-1:0] LD_CHD  = TW'(CHD_CYC - 1);
    localparam logic [TW-1:0] LD_RPS  = TW'(RPS_CYC - 1);

    seq_state_e      state, state_nxt;
    logic            tmr_load, tmr_expired, done_set, accept;
    logic [TW-1:0]   tmr_val;
    strobe_t         strobes;

    // Handshake: which kinds may start depends only on the resting state.
    always_comb begin
        unique case (state)
            ST_IDLE:    req_ready = (req_kind == KIND_CBR) || (req_kind == KIND_SR_ENTER);
            ST_SR_HOLD: req_ready = tmr_expired && (req_kind == KIND_SR_EXIT);
            default:    req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        done_set  = 1'b0;
        unique case (state)
            ST_IDLE: if (accept) begin
                tmr_load = 1'b1;
                tmr_val  = LD_CSR;
                state_nxt = (req_kind == KIND_CBR) ? ST_CBR_SETUP : ST_SR_SETUP;
            end
            ST_CBR_SETUP: if (tmr_expired) begin
                state_nxt = ST_CBR_ACTIVE;
                tmr_load  = 1'b1;
                tmr_val   = LD_RAS;
            end
            ST_CBR_ACTIVE: if (tmr_expired) begin
                state_nxt = ST_CBR_PRECH;
                tmr_load  = 1'b1;
                tmr_val   = LD_RP;
            end
            ST_CBR_PRECH: if (tmr_expired) begin
                state_nxt = ST_IDLE;
                done_set  = 1'b1;
            end
            ST_SR_SETUP: if (tmr_expired) begin
                state_nxt = ST_SR_HOLD;
                tmr_load  = 1'b1;
                tmr_val   = LD_RASS;
                done_set  = 1'b1;
            end
            ST_SR_HOLD: if (accept) begin
                state_nxt = ST_SR_RELEASE;
                tmr_load  = 1'b1;
                tmr_val   = LD_CHD;
            end
            ST_SR_RELEASE: if (tmr_expired) begin
                state_nxt = ST_SR_PRECH;
                tmr_load  = 1'b1;
                tmr_val   = LD_RPS;
            end
            ST_SR_PRECH: if (tmr_expired) begin
                state_nxt = ST_IDLE;
                done_set  = 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nxt;
            done  <= done_set;
        end
    end

    cbr_step_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cbr_strobe_reg u_strobes (
        .clk       (clk),
        .rst       (rst),
        .state_nxt (state_nxt),
        .strobes   (strobes)
    );

    assign ras_n = strobes.ras_n;
    assign cas_n = strobes.cas_n;
    assign we_n  = strobes.we_n;
    assign busy  = (state != ST_IDLE) && (state != ST_SR_HOLD);

    // Run-length observers on the pins, used only by the timing properties.
    logic [TW-1:0] ras_lo_run, ras_hi_run, cas_lo_run;
    localparam logic [TW-1:0] RUN_CAP = TW'(MAX_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo_run <= '0;
            ras_hi_run <= '0;
            cas_lo_run <= '0;
        end else begin
            ras_lo_run <= ras_n ? '0 : ((ras_lo_run == RUN_CAP) ? RUN_CAP : ras_lo_run + 1'b1);
            ras_hi_run <= !ras_n ? '0 : ((ras_hi_run == RUN_CAP) ? RUN_CAP : ras_hi_run + 1'b1);
            cas_lo_run <= cas_n ? '0 : ((cas_lo_run == RUN_CAP) ? RUN_CAP : cas_lo_run + 1'b1);
        end
    end

    a_r1_we_high: assert property (@(posedge clk) disable iff (rst)
        we_n);

    a_r2_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && int'(cas_lo_run) >= CSR_CYC));

    a_r3_cas_hold_after_ras: assert property (@(posedge clk) disable iff (rst)
        ($rose(cas_n) && $past(!ras_n)) |-> (int'(ras_lo_run) >= CHR_CYC));

    a_r6_self_refresh_min: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && !cas_n) |-> (int'(ras_lo_run) >= RASS_CYC));

    a_r7_cas_hold_at_exit: assert property (@(posedge clk) disable iff (rst)
        ($rose(cas_n) && $past(ras_n)) |-> (int'(ras_hi_run) >= CHD_CYC));

    a_r8_no_ready_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/cbr_refresh_seq_bench.sv
`timescale 1ns/1ps
module cbr_refresh_seq_bench;

    localparam int CLK_PS  = 4000;
    localparam int CSR_NS  = 5;
    localparam int CHR_NS  = 10;
    localparam int RAS_NS  = 60;
    localparam int RP_NS   = 40;
    localparam int RASS_NS = 400;
    localparam int CHD_NS  = 10;
    localparam int RPS_NS  = 110;

    function automatic int to_cyc(input int ns);
        int c;
        c = (ns * 1000) / CLK_PS;
        if (c * CLK_PS < ns * 1000) c = c + 1;
        if (c < 1) c = 1;
        return c;
    endfunction

    int csr_c, ras_c, rp_c, rass_c, chd_c, rps_c;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_ready, ras_n, cas_n, we_n, busy, done;

    always #2 clk = ~clk;

    cbr_refresh_seq #(
        .CLK_PS(CLK_PS), .CSR_NS(CSR_NS), .CHR_NS(CHR_NS), .RAS_NS(RAS_NS),
        .RP_NS(RP_NS), .RASS_NS(RASS_NS), .CHD_NS(CHD_NS), .RPS_NS(RPS_NS)
    ) u_cbr_refresh_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    // Reference model: expected waveform queued per accepted request.
    typedef struct packed { logic ras; logic cas; logic bsy; } exp_t;
    exp_t exp_q[$];
    bit   mode_sr = 1'b0;
    int   sr_cycles = 0;
    bit   exp_done = 1'b0;

    function automatic bit exp_ready();
        if (exp_q.size() != 0) return 1'b0;
        if (!mode_sr) return (req_kind == 2'd0) || (req_kind == 2'd1);
        return (req_kind == 2'd2) && (sr_cycles + 1 >= rass_c);
    endfunction

    function automatic void push_n(input logic r, input logic c, input int n);
        exp_t e;
        e.ras = r; e.cas = c; e.bsy = 1'b1;
        for (int i = 0; i < n; i++) exp_q.push_back(e);
    endfunction

    always @(posedge clk) begin
        bit acc;
        if (rst) begin
            exp_q.delete();
            mode_sr = 1'b0;
            sr_cycles = 0;
            exp_done = 1'b0;
        end else begin
            acc = req_valid && exp_ready();
            if (exp_q.size() > 0) begin
                void'(exp_q.pop_front());
                exp_done = (exp_q.size() == 0);
            end else begin
                exp_done = 1'b0;
                if (mode_sr) sr_cycles++;
            end
            if (acc) begin
                case (req_kind)
                    2'd0: begin
                        push_n(1'b1, 1'b0, csr_c);
                        push_n(1'b0, 1'b0, ras_c);
                        push_n(1'b1, 1'b1, rp_c);
                    end
                    2'd1: begin
                        push_n(1'b1, 1'b0, csr_c);
                        mode_sr = 1'b1;
                        sr_cycles = 0;
                    end
                    default: begin
                        push_n(1'b1, 1'b0, chd_c);
                        push_n(1'b1, 1'b1, rps_c);
                        mode_sr = 1'b0;
                    end
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, expv, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge and after input changes.
    always @(negedge clk) begin
        logic er, ec, eb, erd;
        #1;
        if (done) done_seen++;
        if (chk_en && !rst) begin
            if (exp_q.size() > 0) begin
                er = exp_q[0].ras; ec = exp_q[0].cas; eb = exp_q[0].bsy;
            end else begin
                er = !mode_sr; ec = !mode_sr; eb = 1'b0;
            end
            erd = exp_ready();
            checks++;
            if (ras_n !== er) begin errors++; $display("FAIL R2 R3 R4 R5 R7 ras_n actual=%0b expected=%0b at %0t", ras_n, er, $time); end
            if (cas_n !== ec) begin errors++; $display("FAIL R2 R3 R5 R7 cas_n actual=%0b expected=%0b at %0t", cas_n, ec, $time); end
            if (we_n !== 1'b1) begin errors++; $display("FAIL R1 we_n actual=%0b expected=1 at %0t", we_n, $time); end
            if (busy !== eb) begin errors++; $display("FAIL R9 busy actual=%0b expected=%0b at %0t", busy, eb, $time); end
            if (done !== exp_done) begin errors++; $display("FAIL R10 done actual=%0b expected=%0b at %0t", done, exp_done, $time); end
            if (req_ready !== erd) begin errors++; $display("FAIL R6 R8 req_ready actual=%0b expected=%0b at %0t", req_ready, erd, $time); end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [1:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd0;
    endtask

    task automatic hold_req(input logic [1:0] k, input int n);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k;
        wait_cycles(n);
        req_valid = 1'b0; req_kind = 2'd0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int waited;
        csr_c  = to_cyc(CSR_NS);
        ras_c  = (to_cyc(RAS_NS) > to_cyc(CHR_NS)) ? to_cyc(RAS_NS) : to_cyc(CHR_NS);
        rp_c   = to_cyc(RP_NS);
        rass_c = to_cyc(RASS_NS);
        chd_c  = to_cyc(CHD_NS);
        rps_c  = to_cyc(RPS_NS);

        wait_cycles(4);
        rst = 1'b0;
        @(negedge clk); #1;
        // R11: reset state
        check(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R11 reset strobes", {ras_n, cas_n, we_n}, 7);
        check(busy === 1'b0 && done === 1'b0, "R11 reset busy/done", {busy, done}, 0);
        chk_en = 1'b1;

        // R2 R3 R4: single refresh
        pulse_req(2'd0);
        wait_cycles(40);

        // R8: held request gives back-to-back refreshes
        hold_req(2'd0, 30);
        wait_cycles(40);

        // R8: unused kind never accepted
        @(negedge clk); req_valid = 1'b1; req_kind = 2'd3; #1;
        check(req_ready === 1'b0, "R8 kind3 ready", req_ready, 0);
        wait_cycles(20);
        req_valid = 1'b0; req_kind = 2'd0;
        // R8: exit while idle is held off
        hold_req(2'd2, 10);
        wait_cycles(5);

        // R5 R6 R7: enter, refresh held off, early exit waits
        pulse_req(2'd1);
        wait_cycles(csr_c + 2);
        @(negedge clk); req_valid = 1'b1; req_kind = 2'd0; #1;
        check(req_ready === 1'b0, "R8 refresh in self refresh ready", req_ready, 0);
        wait_cycles(10);
        req_kind = 2'd2; #1;
        check(req_ready === 1'b0, "R6 early exit ready", req_ready, 0);
        waited = 0;
        while (!req_ready) begin
            @(negedge clk); #1;
            waited++;
        end
        check(waited > 0, "R6 early exit waited", waited, 1);
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd0;
        wait_cycles(40);

        // R5 R7: long rest then exit
        pulse_req(2'd1);
        wait_cycles(rass_c + 20);
        pulse_req(2'd2);
        wait_cycles(40);

        // R11: reset in the middle of a refresh
        pulse_req(2'd0);
        wait_cycles(6);
        rst = 1'b1;
        wait_cycles(2);
        rst = 1'b0;
        #1;
        check(ras_n === 1'b1 && cas_n === 1'b1 && busy === 1'b0, "R11 mid-sequence reset", {ras_n, cas_n, busy}, 6);
        wait_cycles(10);

        pulse_req(2'd0);
        wait_cycles(40);

        // R10: one done pulse per completed operation
        check(done_seen == 8, "R10 done pulse count", done_seen, 8);
        summary();
    end

endmodule